// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block sets the clock pace for the master side of a byte-oriented I2C serial port. It reads a 3-bit rate code from the serial control byte. Seven code values select a fixed oscillator divisor. The eighth value clocks the bit period from the overflow pulses of an external 8-bit auto-reload timer. The block pulls SCL low through an open-drain control and releases it to let it rise. It starts timing the high phase only once the wire has actually gone high, so a slave that holds SCL low stretches the clock.

Both incoming bus lines pass through a two-flop synchroniser and a spike filter before any logic uses them. The filter rejects a level that lasts fewer than three oscillator clocks. The filtered SCL and SDA go to the downstream byte engine, together with two single-cycle strobes:

- one marks each SCL rising edge, where data is sampled;
- one marks each falling edge, where data may change.

The generator runs continuously while the enable bit of the control byte is set. It is idle, with SCL released, while that bit is clear.

Top module: `i2c_scl_rategen`

## Requirements
- R1: While reset is asserted, and right after it, `scl_drive_low` is 0, both strobes are 0, and `scl_filt` and `sda_filt` are 1.
- R2: Bit 6 of `ctl_byte` is the enable. While it is 0, `scl_drive_low` and both strobes stay 0. If the bit is cleared during a low phase, SCL is released in the next cycle.
- R3: The rate code is {`ctl_byte[7]`, `ctl_byte[1]`, `ctl_byte[0]`}. Bits 5 down to 2 have no effect on the timing.
- R4: For rate codes 000 to 110, one SCL period is 256, 224, 192, 160, 960, 120 or 60 clocks respectively. `scl_drive_low` stays high for exactly half of that divisor, starting in the cycle of `scl_fall_stb`.
- R5: For rate codes 000 to 110, `scl_fall_stb` follows `scl_rise_stb` by exactly half the divisor in clocks.
- R6: Rate code 111 counts `tmr_ovf` pulses instead of clocks, 96 per period: 48 in the low phase and 48 in the high phase. Without pulses the generator makes no progress.
- R7: The high-phase count starts only once `scl_filt` is 1. While SCL is held low externally, no `scl_rise_stb` appears. When an external holder releases SCL, `scl_rise_stb` is high 6 clocks later.
- R8: A level on a raw line lasting fewer than 3 clocks does not reach the filtered output. A level of 3 clocks or more does reach it, appearing 5 clocks after the raw change.
- R9: Each strobe lasts one cycle. The two strobes never coincide. `scl_fall_stb` is high in the first cycle of `scl_drive_low`.
- R10: For every rate code, the low phase lasts at least 16 clocks and the counted high phase at least 14 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_byte | input | 8 | Serial control byte: rate code in bits 7, 1 and 0; enable in bit 6 |
| tmr_ovf | input | 1 | One-clock overflow pulse from the 8-bit reload timer |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| scl_filt | output | 1 | Synchronised and spike-filtered SCL |
| sda_filt | output | 1 | Synchronised and spike-filtered SDA |
| scl_rise_stb | output | 1 | One-cycle strobe when a counted high phase begins |
| scl_fall_stb | output | 1 | One-cycle strobe when SCL is pulled low |

## Verification
A phase counter that ends early or late shows up within one SCL period as a wrong number of cycles between the two strobes, or a wrong low-pulse width, on the ports. A wrong divisor entry or a mis-decoded code bit shows up the same way. A filter with the wrong length either lets a two-clock glitch through or shifts the filtered edge away from its fixed five-clock delay, so a single injected pulse exposes it. A stretch handler that starts counting before the wire is high places the rise strobe too early after an external release, which is visible in the first stretched period.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WAIT_HI = 2'd1,
    PH_HIGH    = 2'd2,
    PH_LOW     = 2'd3
  } phase_e;

  localparam logic [2:0] RATE_TIMER = 3'b111;

  // Oscillator clocks per SCL period for the fixed codes; the table is not monotonic.
  function automatic int unsigned osc_divisor(input logic [2:0] code);
    case (code)
      3'b000:  return 256;
      3'b001:  return 224;
      3'b010:  return 192;
      3'b011:  return 160;
      3'b100:  return 960;
      3'b101:  return 120;
      3'b110:  return 60;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sclgen_filter.sv
module sclgen_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_filt
);
  localparam int RW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_sync;
  logic [RW-1:0]          run_q;
  logic                   filt_q;

  assign line_sync = sync_q[SYNC_STAGES-1];
  assign line_filt = filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end
  end

  // A new level must be seen FILT_LEN times in a row before it is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b1;
    end else if (line_sync == filt_q) begin
      run_q <= '0;
    end else if (run_q == RW'(FILT_LEN - 1)) begin
      run_q  <= '0;
      filt_q <= line_sync;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  generate
    if (FILT_LEN == 3) begin : g_chk3
      AST_FILT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |->
          ($past(line_sync, 1) == filt_q && $past(line_sync, 2) == filt_q &&
           $past(line_sync, 3) == filt_q)); // R8
    end
  endgenerate

endmodule

// File: rtl/sclgen_rate.sv
module sclgen_rate
  import sclgen_pkg::*;
#(
  parameter int TMR_TICKS = 96,
  parameter int CNT_W     = 10
) (
  input  logic [2:0]       code,
  input  logic             tmr_ovf,
  output logic             tick,
  output logic [CNT_W-1:0] half_cnt
);
  localparam int TMR_HALF = TMR_TICKS / 2;

  always_comb begin
    if (code == RATE_TIMER) begin
      tick     = tmr_ovf;
      half_cnt = CNT_W'(TMR_HALF);
    end else begin
      tick     = 1'b1;
      half_cnt = CNT_W'(osc_divisor(code) >> 1);
    end
  end

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import sclgen_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_LOW  = 16,
  parameter int MIN_HIGH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] half_cnt,
  input  logic             scl_filt,
  output logic             drive_low,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int RUN_W = CNT_W + 1;

  phase_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RUN_W-1:0] lowrun_q, hirun_q;
  logic             cnt_last, lo_done, hi_done, hi_start;

  // ">=" lets a phase end at once if the code shrinks mid-phase.
  assign cnt_last  = (RUN_W'(cnt_q) + RUN_W'(1)) >= RUN_W'(half_cnt);
  assign lo_done   = (state_q == PH_LOW)  && tick && cnt_last;
  assign hi_done   = (state_q == PH_HIGH) && tick && cnt_last;
  assign hi_start  = (state_q == PH_WAIT_HI) && scl_filt;
  assign drive_low = (state_q == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      cnt_q    <= '0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      if (!en) begin
        state_q <= PH_IDLE;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          PH_IDLE: begin
            state_q <= PH_WAIT_HI;
            cnt_q   <= '0;
          end
          PH_WAIT_HI: begin
            if (hi_start) begin
              state_q  <= PH_HIGH;
              cnt_q    <= '0;
              rise_stb <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (hi_done) begin
              state_q  <= PH_LOW;
              cnt_q    <= '0;
              fall_stb <= 1'b1;
            end else if (tick) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            if (lo_done) begin
              state_q <= PH_WAIT_HI;
              cnt_q   <= '0;
            end else if (tick) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // Clock-based run lengths of each phase, kept for the width checks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowrun_q <= '0;
      hirun_q  <= '0;
    end else begin
      lowrun_q <= (state_q == PH_LOW)  ? ((&lowrun_q) ? lowrun_q : lowrun_q + 1'b1) : '0;
      hirun_q  <= (state_q == PH_HIGH) ? ((&hirun_q)  ? hirun_q  : hirun_q  + 1'b1) : '0;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drive_low && !rise_stb && !fall_stb)); // R2
  AST_RISE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $past(scl_filt)); // R7
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb); // R9
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb); // R9
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb)); // R9
  AST_FALL_WITH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> fall_stb); // R9
  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    lo_done |-> (lowrun_q >= RUN_W'(MIN_LOW - 1))); // R10
  AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    hi_done |-> (hirun_q >= RUN_W'(MIN_HIGH - 1))); // R10

endmodule

// File: rtl/i2c_scl_rategen.sv
module i2c_scl_rategen #(
  parameter int TMR_TICKS   = 96,
  parameter int MAX_OSC_DIV = 960,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 16,
  parameter int MIN_HIGH    = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctl_byte,
  input  logic       tmr_ovf,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       scl_filt,
  output logic       sda_filt,
  output logic       scl_rise_stb,
  output logic       scl_fall_stb
);
  localparam int CNT_W   = $clog2(MAX_OSC_DIV);
  localparam int EN_BIT  = 6;
  localparam int RC2_BIT = 7;
  localparam int RC1_BIT = 1;
  localparam int RC0_BIT = 0;
  localparam int N_LINES = 2;

  logic [2:0]         rate_code;
  logic               gen_en, tick;
  logic [CNT_W-1:0]   half_cnt;
  logic [N_LINES-1:0] raw_lines, filt_lines;

  assign rate_code = {ctl_byte[RC2_BIT], ctl_byte[RC1_BIT], ctl_byte[RC0_BIT]};
  assign gen_en    = ctl_byte[EN_BIT];
  assign raw_lines = {sda_in, scl_in};
  assign scl_filt  = filt_lines[0];
  assign sda_filt  = filt_lines[1];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    sclgen_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (raw_lines[g]),
      .line_filt(filt_lines[g])
    );
  end

  sclgen_rate #(.TMR_TICKS(TMR_TICKS), .CNT_W(CNT_W)) u_rate (
    .code    (rate_code),
    .tmr_ovf (tmr_ovf),
    .tick    (tick),
    .half_cnt(half_cnt)
  );

  sclgen_phase #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (gen_en),
    .tick     (tick),
    .half_cnt (half_cnt),
    .scl_filt (scl_filt),
    .drive_low(scl_drive_low),
    .rise_stb (scl_rise_stb),
    .fall_stb (scl_fall_stb)
  );

endmodule

// File: tb/i2c_scl_rategen_test.sv
module i2c_scl_rategen_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 8;
  // {control byte, expected half period in clocks}
  localparam logic [17:0] VECS [N_VEC] = '{
    {8'h40, 10'd128}, {8'h41, 10'd112}, {8'h42, 10'd96}, {8'h43, 10'd80},
    {8'hC0, 10'd480}, {8'hC1, 10'd60},  {8'hC2, 10'd30}, {8'h7E, 10'd96}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctl_byte = 8'h00;
  logic       tmr_ovf = 1'b0;
  logic       tmr_run = 1'b0;
  logic       ext_hold = 1'b0;
  logic       sda_in = 1'b1;
  logic       scl_in;
  logic       scl_drive_low, scl_filt, sda_filt, scl_rise_stb, scl_fall_stb;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  assign scl_in = ~(scl_drive_low | ext_hold);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_rategen uut (
    .clk(clk), .rst_n(rst_n), .ctl_byte(ctl_byte), .tmr_ovf(tmr_ovf),
    .scl_in(scl_in), .sda_in(sda_in), .scl_drive_low(scl_drive_low),
    .scl_filt(scl_filt), .sda_filt(sda_filt),
    .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb)
  );

  // Overflow pulse every third clock, driven just after the rising edge.
  initial begin
    int div = 0;
    forever begin
      @(posedge clk);
      #2;
      tmr_ovf = tmr_run && (div == 2);
      div = (div == 2) ? 0 : div + 1;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_strobe(input bit want_fall, output bit ok);
    ok = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (want_fall ? scl_fall_stb : scl_rise_stb) begin
        ok = 1;
        break;
      end
    end
  endtask

  task automatic pulse_line(input bit on_scl, input int w, output int first, output int lows);
    first = 0;
    lows = 0;
    @(negedge clk);
    if (on_scl) ext_hold = 1'b1; else sda_in = 1'b0;
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      if ((on_scl ? scl_filt : sda_filt) == 1'b0) begin
        lows++;
        if (first == 0) first = j;
      end
      if (j == w) begin
        if (on_scl) ext_hold = 1'b0; else sda_in = 1'b1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit ok;
    int n, d, first, lows, chg;
    logic dl;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 drive during reset", scl_drive_low, 0);
    check("R1 scl_filt during reset", scl_filt, 1);
    check("R1 sda_filt during reset", sda_filt, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rise strobe after reset", scl_rise_stb, 0);
    check("R1 fall strobe after reset", scl_fall_stb, 0);

    // R8: spike filter on both lines
    pulse_line(0, 2, first, lows);
    check("R8 sda 2-clock glitch rejected", lows, 0);
    pulse_line(0, 3, first, lows);
    check("R8 sda 3-clock level accepted", lows, 3);
    check("R8 sda filtered latency", first, 5);
    pulse_line(1, 2, first, lows);
    check("R8 scl 2-clock glitch rejected", lows, 0);
    pulse_line(1, 4, first, lows);
    check("R8 scl 4-clock level accepted", lows, 4);

    // R2: enable clear, other bits set, timer running
    tmr_run = 1'b1;
    ctl_byte = 8'hBF;
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (scl_drive_low || scl_rise_stb || scl_fall_stb) n++;
    end
    check("R2 disabled generator stays quiet", n, 0);
    tmr_run = 1'b0;

    // R3 R4 R5 R9 R10: table of rate codes
    for (int i = 0; i < N_VEC; i++) begin
      int exp_half;
      ctl_byte = 8'h00;
      repeat (3) @(negedge clk);
      ctl_byte = VECS[i][17:10];
      exp_half = int'(VECS[i][9:0]);
      wait_strobe(1, ok);
      check($sformatf("R9 fall strobe seen vec%0d", i), ok, 1);
      check($sformatf("R9 low starts with fall strobe vec%0d", i), scl_drive_low, 1);
      n = 0;
      while (scl_drive_low && n < 5000) begin
        n++;
        @(negedge clk);
      end
      check($sformatf("%s low width vec%0d", (i == 7) ? "R3" : "R4", i), n, exp_half);
      check($sformatf("R10 low at least 16 vec%0d", i), int'(n >= 16), 1);
      wait_strobe(0, ok);
      check($sformatf("R9 rise strobe seen vec%0d", i), ok, 1);
      d = 0;
      do begin
        @(negedge clk);
        d++;
        if (d == 1) check($sformatf("R9 rise strobe one cycle vec%0d", i), scl_rise_stb, 0);
      end while (!scl_fall_stb && d < 5000);
      check($sformatf("R5 rise to fall vec%0d", i), d, exp_half);
      check($sformatf("R10 high at least 14 vec%0d", i), int'(d >= 14), 1);
    end

    // R2: clearing enable during the low phase releases SCL at once
    ctl_byte = 8'h00;
    repeat (3) @(negedge clk);
    ctl_byte = 8'hC2;
    wait_strobe(1, ok);
    ctl_byte = 8'h00;
    @(negedge clk);
    check("R2 release after enable cleared", scl_drive_low, 0);

    // R7: clock stretching by an external holder
    repeat (3) @(negedge clk);
    ctl_byte = 8'hC2;
    wait_strobe(1, ok);
    ext_hold = 1'b1;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (scl_rise_stb) n++;
    end
    check("R7 no rise while held low", n, 0);
    ext_hold = 1'b0;
    d = 0;
    do begin
      @(negedge clk);
      d++;
    end while (!scl_rise_stb && d < 1000);
    check("R7 rise delay after release", d, 6);
    d = 0;
    do begin
      @(negedge clk);
      d++;
    end while (!scl_fall_stb && d < 1000);
    check("R7 high count after stretch", d, 30);

    // R6: timer overflow clocking
    ctl_byte = 8'h00;
    repeat (3) @(negedge clk);
    tmr_run = 1'b1;
    ctl_byte = 8'hC3;
    wait_strobe(1, ok);
    n = 0;
    while (scl_drive_low && n < 1000) begin
      if (tmr_ovf) n++;
      @(negedge clk);
    end
    check("R6 overflow pulses in low phase", n, 48);
    wait_strobe(0, ok);
    n = 0;
    d = 0;
    while (!scl_fall_stb && d < 2000) begin
      if (tmr_ovf) n++;
      @(negedge clk);
      d++;
    end
    check("R6 overflow pulses in high phase", n, 48);
    tmr_run = 1'b0;
    @(negedge clk);
    dl = scl_drive_low;
    chg = 0;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (scl_rise_stb || scl_fall_stb) n++;
      if (scl_drive_low != dl) chg++;
    end
    check("R6 no strobes without overflow", n, 0);
    check("R6 drive frozen without overflow", chg, 0);

    ctl_byte = 8'h00;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule